// File: doc/BRIEF.md
# Logical AND Execute Unit

This unit sits in the execute stage of a byte-coded legacy instruction pipeline and handles every encoding of the bitwise AND operation. The front end has already fetched the opcode byte, the reg field of the ModRM byte, the current operand-size attribute and both operand values. When the source is an immediate, its value sits right-justified in the source input. The unit decodes the encoding, forms the AND at the correct width and computes the status flags. On the next clock edge it presents the result, the width code, and whether the result goes back to the r/m operand or to a register.

Encodings outside the AND family are reported through a not-AND indication. Immediate-group opcodes whose reg field selects a different operation are reported the same way. A rejected encoding does not disturb the flag outputs, the result, the width code or the write-back select. There is one cycle of latency and a new operation can be accepted on every clock cycle.

Top module: `logic_and_unit`

## Requirements
- R1: After reset, `res_valid`, `not_and`, all flag outputs, `result`, `res_width` and `wr_rm` are all 0.
- R2: Opcode 0x24 is an 8-bit AND and opcode 0x25 is an operand-size AND (16 when `opsize32`=0, 32 when it is 1). Both target the accumulator, so `wr_rm`=0. `res_width` encodes 0 for 8 bits, 1 for 16 bits and 2 for 32 bits.
- R3: Opcodes 0x80 (8-bit), 0x81 (operand-size) and 0x83 (operand-size) are accepted as AND only when `modrm_reg` equals 4. They then set `wr_rm`=1.
- R4: For opcode 0x83, bits 7:0 of `src_val` are sign-extended to the operand size before the AND. Higher bits of `src_val` are ignored.
- R5: Opcodes 0x20 (8-bit) and 0x21 (operand-size) write to r/m (`wr_rm`=1). Opcodes 0x22 (8-bit) and 0x23 (operand-size) write to a register (`wr_rm`=0).
- R6: `result` equals `dst_val` AND the source at the active width, and every bit above that width is 0.
- R7: On every accepted AND, `flag_of` and `flag_cf` are 0. `flag_af` is always driven 0, but its value is architecturally undefined.
- R8: `flag_sf` equals the top bit of the result at the active width. `flag_zf` is 1 exactly when the active-width result is 0.
- R9: `flag_pf` is 1 when bits 7:0 of the result hold an even number of ones.
- R10: A rejected encoding gives `not_and`=1. This covers 0x80/0x81/0x83 with a reg field other than 4, and any opcode outside the family. In that case the flags, `result`, `res_width` and `wr_rm` keep their previous values.
- R11: `res_valid` is high in exactly the cycle after an edge that sampled `in_valid`=1. `not_and` is 0 whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the inputs |
| opcode | input | 8 | Primary opcode byte |
| modrm_reg | input | 3 | Reg field of the ModRM byte |
| opsize32 | input | 1 | Operand-size attribute: 1 = 32-bit, 0 = 16-bit |
| dst_val | input | 32 | Destination operand value |
| src_val | input | 32 | Source operand value or right-justified immediate |
| res_valid | output | 1 | Outputs belong to a completed operation |
| not_and | output | 1 | Encoding was not an AND |
| result | output | 32 | AND result, zero above the active width |
| res_width | output | 2 | Width code: 0 = 8, 1 = 16, 2 = 32 |
| wr_rm | output | 1 | 1 = write back to r/m, 0 = to register/accumulator |
| flag_of | output | 1 | Overflow flag |
| flag_cf | output | 1 | Carry flag |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_pf | output | 1 | Parity flag |
| flag_af | output | 1 | Auxiliary-carry flag (held 0) |

## Verification
Operand pairs are chosen so that each decoding choice produces a different value. Destinations carry ones above bit 7 and above bit 15, so an 8-bit or 16-bit operation that fails to mask shows stray upper bits. Immediates with bit 7 set separate sign extension from zero extension, and a wide `src_val` with junk above bit 7 exposes any failure to discard it under 0x83. Further operand pairs force a zero result, a set top bit at each width, and odd and even low-byte parity. Rejected encodings follow an accepted one with known flags, so any change to the held state is visible at the outputs.

// File: rtl/logic_and_unit.sv
module logic_and_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [2:0]  modrm_reg,
  input  logic        opsize32,
  input  logic [31:0] dst_val,
  input  logic [31:0] src_val,
  output logic        res_valid,
  output logic        not_and,
  output logic [31:0] result,
  output logic [1:0]  res_width,
  output logic        wr_rm,
  output logic        flag_of,
  output logic        flag_cf,
  output logic        flag_sf,
  output logic        flag_zf,
  output logic        flag_pf,
  output logic        flag_af
);

  localparam logic [2:0] GRP_AND = 3'd4;

  logic        is_and, byte_op, to_rm, sext8;
  logic [1:0]  wcode;
  logic [31:0] mask, src_x, res_c;
  logic        sign_c;

  always_comb begin
    is_and  = 1'b1;
    byte_op = 1'b0;
    to_rm   = 1'b0;
    sext8   = 1'b0;
    case (opcode)
      8'h20: begin byte_op = 1'b1; to_rm = 1'b1; end
      8'h21: to_rm = 1'b1;
      8'h22: byte_op = 1'b1;
      8'h23: ;
      8'h24: byte_op = 1'b1;
      8'h25: ;
      8'h80: begin byte_op = 1'b1; to_rm = 1'b1; is_and = (modrm_reg == GRP_AND); end
      8'h81: begin to_rm = 1'b1; is_and = (modrm_reg == GRP_AND); end
      8'h83: begin to_rm = 1'b1; sext8 = 1'b1; is_and = (modrm_reg == GRP_AND); end
      default: is_and = 1'b0;
    endcase
  end

  assign wcode  = byte_op ? 2'd0 : (opsize32 ? 2'd2 : 2'd1);
  assign mask   = byte_op ? 32'h0000_00FF : (opsize32 ? 32'hFFFF_FFFF : 32'h0000_FFFF);
  assign src_x  = sext8 ? {{24{src_val[7]}}, src_val[7:0]} : src_val;
  assign res_c  = dst_val & src_x & mask;
  assign sign_c = byte_op ? res_c[7] : (opsize32 ? res_c[31] : res_c[15]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      not_and   <= 1'b0;
      result    <= '0;
      res_width <= 2'd0;
      wr_rm     <= 1'b0;
      flag_of   <= 1'b0;
      flag_cf   <= 1'b0;
      flag_sf   <= 1'b0;
      flag_zf   <= 1'b0;
      flag_pf   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      not_and   <= in_valid & ~is_and;
      if (in_valid && is_and) begin
        result    <= res_c;
        res_width <= wcode;
        wr_rm     <= to_rm;
        flag_of   <= 1'b0;
        flag_cf   <= 1'b0;
        flag_sf   <= sign_c;
        flag_zf   <= (res_c == 32'd0);
        flag_pf   <= ~^res_c[7:0];
      end
    end
  end

  assign flag_af = 1'b0;

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !not_and);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !not_and) |-> (!flag_of && !flag_cf));

  // R6
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !not_and && res_width == 2'd0) |-> (result[31:8] == 24'd0));

  // R6
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !not_and && res_width == 2'd1) |-> (result[31:16] == 16'd0));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !not_and) |-> (flag_zf == (result == 32'd0)));

  // R9
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !not_and) |-> (flag_pf == ~^result[7:0]));

  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && not_and) |-> ($stable(flag_sf) && $stable(flag_zf) &&
                                $stable(flag_pf) && $stable(result) && $stable(wr_rm)));

endmodule

// File: tb/test_logic_and_unit.sv
module test_logic_and_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [2:0]  modrm_reg = 3'd0;
  logic        opsize32 = 1'b0;
  logic [31:0] dst_val = '0;
  logic [31:0] src_val = '0;
  logic        res_valid, not_and, wr_rm;
  logic [31:0] result;
  logic [1:0]  res_width;
  logic        flag_of, flag_cf, flag_sf, flag_zf, flag_pf, flag_af;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] e_res = '0;
  logic [1:0]  e_w = 2'd0;
  logic        e_rm = 1'b0, e_sf = 1'b0, e_zf = 1'b0, e_pf = 1'b0;

  always #4 clk = ~clk;

  logic_and_unit i_logic_and_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .modrm_reg(modrm_reg), .opsize32(opsize32), .dst_val(dst_val), .src_val(src_val),
    .res_valid(res_valid), .not_and(not_and), .result(result), .res_width(res_width),
    .wr_rm(wr_rm), .flag_of(flag_of), .flag_cf(flag_cf), .flag_sf(flag_sf),
    .flag_zf(flag_zf), .flag_pf(flag_pf), .flag_af(flag_af)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [7:0] op, input logic [2:0] rg,
                        input logic sz, input logic [31:0] d, input logic [31:0] s);
    logic legal, b8, rm, sx;
    logic [31:0] m, sv;
    legal = 1'b1; b8 = 1'b0; rm = 1'b0; sx = 1'b0;
    case (op)
      8'h20: begin b8 = 1'b1; rm = 1'b1; end
      8'h21: rm = 1'b1;
      8'h22, 8'h24: b8 = 1'b1;
      8'h23, 8'h25: ;
      8'h80: begin b8 = 1'b1; rm = 1'b1; legal = (rg == 3'd4); end
      8'h81: begin rm = 1'b1; legal = (rg == 3'd4); end
      8'h83: begin rm = 1'b1; sx = 1'b1; legal = (rg == 3'd4); end
      default: legal = 1'b0;
    endcase
    @(negedge clk);
    in_valid = 1'b1; opcode = op; modrm_reg = rg; opsize32 = sz; dst_val = d; src_val = s;
    @(negedge clk);
    in_valid = 1'b0; opcode = 8'h00;
    if (legal) begin
      m = b8 ? 32'hFF : (sz ? 32'hFFFF_FFFF : 32'hFFFF);
      sv = sx ? {{24{s[7]}}, s[7:0]} : s;
      e_res = d & sv & m;
      e_w = b8 ? 2'd0 : (sz ? 2'd2 : 2'd1);
      e_rm = rm;
      e_sf = b8 ? e_res[7] : (sz ? e_res[31] : e_res[15]);
      e_zf = (e_res == 0);
      e_pf = ~^e_res[7:0];
    end
    cmp(tag, "res_valid (R11)", {31'd0, res_valid}, 32'd1);
    cmp(tag, "not_and (R10)", {31'd0, not_and}, {31'd0, ~legal});
    cmp(tag, "result (R6)", result, e_res);
    cmp(tag, "res_width", {30'd0, res_width}, {30'd0, e_w});
    cmp(tag, "wr_rm", {31'd0, wr_rm}, {31'd0, e_rm});
    cmp(tag, "flag_sf (R8)", {31'd0, flag_sf}, {31'd0, e_sf});
    cmp(tag, "flag_zf (R8)", {31'd0, flag_zf}, {31'd0, e_zf});
    cmp(tag, "flag_pf (R9)", {31'd0, flag_pf}, {31'd0, e_pf});
    cmp(tag, "flag_of (R7)", {31'd0, flag_of}, 32'd0);
    cmp(tag, "flag_cf (R7)", {31'd0, flag_cf}, 32'd0);
  endtask

  task automatic t_reset();
    cmp("R1", "res_valid", {31'd0, res_valid}, 32'd0);
    cmp("R1", "not_and", {31'd0, not_and}, 32'd0);
    cmp("R1", "result", result, 32'd0);
    cmp("R1", "res_width", {30'd0, res_width}, 32'd0);
    cmp("R1", "wr_rm", {31'd0, wr_rm}, 32'd0);
    cmp("R1", "flags", {26'd0, flag_of, flag_cf, flag_sf, flag_zf, flag_pf, flag_af}, 32'd0);
  endtask

  task automatic t_accum();
    run_op("R2", 8'h24, 3'd0, 1'b1, 32'hABCD_12F3, 32'h0000_000F);
    run_op("R2", 8'h25, 3'd7, 1'b0, 32'hFFFF_8F0F, 32'h1234_F00F);
    run_op("R2", 8'h25, 3'd2, 1'b1, 32'h8765_4321, 32'hF0F0_F0F0);
  endtask

  task automatic t_group();
    run_op("R3", 8'h80, 3'd4, 1'b1, 32'hFFFF_FF81, 32'h0000_0080);
    run_op("R3", 8'h81, 3'd4, 1'b0, 32'hFFFF_C3C3, 32'h0000_8181);
    run_op("R3", 8'h81, 3'd4, 1'b1, 32'hDEAD_BEEF, 32'h0F0F_0F0F);
  endtask

  task automatic t_sext();
    run_op("R4", 8'h83, 3'd4, 1'b1, 32'hFFFF_FFFF, 32'h0000_0080);
    run_op("R4", 8'h83, 3'd4, 1'b0, 32'hFFFF_FFFF, 32'h0000_00F0);
    run_op("R4", 8'h83, 3'd4, 1'b1, 32'hFFFF_FFFF, 32'h5555_007F);
  endtask

  task automatic t_regforms();
    run_op("R5", 8'h20, 3'd1, 1'b1, 32'h1234_56FF, 32'hFFFF_FF3C);
    run_op("R5", 8'h21, 3'd3, 1'b0, 32'h0000_FFFF, 32'hFFFF_8001);
    run_op("R5", 8'h22, 3'd5, 1'b1, 32'hFFFF_FFAA, 32'h0000_0055);
    run_op("R5", 8'h23, 3'd6, 1'b1, 32'hC000_0001, 32'h8000_0003);
  endtask

  task automatic t_flags();
    run_op("R8", 8'h21, 3'd0, 1'b1, 32'hFFFF_0000, 32'h0000_FFFF);
    run_op("R8", 8'h21, 3'd0, 1'b0, 32'h0001_8000, 32'hFFFF_FFFF);
    run_op("R9", 8'h24, 3'd0, 1'b0, 32'h0000_0007, 32'h0000_00FF);
    run_op("R7", 8'h25, 3'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_reject();
    run_op("R10", 8'h81, 3'd4, 1'b1, 32'h8000_0003, 32'hFFFF_FFFF);
    run_op("R10", 8'h80, 3'd3, 1'b0, 32'h0000_0000, 32'h0000_0000);
    run_op("R10", 8'h83, 3'd0, 1'b1, 32'h0000_0000, 32'h0000_0001);
    run_op("R10", 8'h0F, 3'd4, 1'b1, 32'h0000_0000, 32'h0000_0000);
    run_op("R10", 8'h26, 3'd4, 1'b0, 32'h0000_0000, 32'h0000_0000);
  endtask

  task automatic t_latency();
    run_op("R11", 8'h24, 3'd0, 1'b0, 32'h0000_00F0, 32'h0000_00F0);
    @(negedge clk);
    cmp("R11", "res_valid idle", {31'd0, res_valid}, 32'd0);
    cmp("R11", "not_and idle", {31'd0, not_and}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_accum();
    t_group();
    t_sext();
    t_regforms();
    t_flags();
    t_reject();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule